// File: doc/BRIEF.md
# Program Memory Read Guard

This block sits beside an on-chip program store and rules on every read presented to it. Each request states who is reading: an instruction fetch, a table-lookup read, or an external programmer reading either the code array or the security settings byte. A flag also tells whether the table-lookup instruction itself was executed from internal or external code space. The block answers one cycle later with an allow/deny flag, the byte to return, and a violation pulse for denied reads.

A security byte holds four live fields. Bit 0 locks out the programmer when cleared. Bit 1, when cleared, stops table reads that run from external code from seeing the internal array. Bit 2, when cleared, turns on scrambling of bytes that the programmer reads out over the external bus. Bit 7 picks the oscillator gain. Programming can only clear bits. A full erase returns every bit to 1 and clears the scrambling key.

Top module: `pmem_guard`

## Requirements
- R1: After reset, and in the cycle after `erase_i`, the security byte reads FFh and the scrambling key is 00h.
- R2: A security write is a bitwise AND of the old value with `sec_wdata_i`, applied to bits 0, 1, 2 and 7 only. Bits 6 to 3 always read 1. If `erase_i` and `sec_we_i` are high in the same cycle, the erase wins.
- R3: An instruction fetch (`req_kind_i` = 2'b00) is always allowed and returns `mem_rdata_i` unchanged.
- R4: A table read (`req_kind_i` = 2'b01) with `req_ext_code_i` = 1 while bit 1 = 0 is denied when the address is below 4000h, and allowed at 4000h and above.
- R5: A table read with `req_ext_code_i` = 0 is always allowed. While bit 1 = 1, every table read is allowed.
- R6: While bit 0 = 0, programmer array reads (2'b10) and settings reads (2'b11) are denied.
- R7: While bit 2 = 0, an allowed programmer array read returns `mem_rdata_i` XOR key. Fetches, table reads and settings reads are never scrambled.
- R8: A denied read returns FFh with `rsp_allow_o` = 0 and `viol_o` = 1 for that response cycle. An allowed read leaves `viol_o` at 0.
- R9: Each request accepted on a clock edge produces `rsp_valid_o` = 1 for exactly the following cycle. Without a request, `rsp_valid_o` and `viol_o` stay 0.
- R10: `osc_full_gain_o` follows bit 7 of the security byte.
- R11: Once bit 2 has been cleared, a write of FFh does not set it again. Only an erase does.
- R12: A settings read (2'b11) that is allowed returns the security byte itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_i | input | 1 | Full erase: security byte to FFh, key to 00h |
| sec_we_i | input | 1 | Security byte program strobe |
| sec_wdata_i | input | 8 | Program value (bits can only be cleared) |
| key_we_i | input | 1 | Scrambling key write strobe |
| key_wdata_i | input | 8 | New key value |
| req_valid_i | input | 1 | Read request present |
| req_kind_i | input | 2 | 00 fetch, 01 table read, 10 programmer array read, 11 programmer settings read |
| req_ext_code_i | input | 1 | Table read issued from external code space |
| req_addr_i | input | 16 | Program address |
| mem_rdata_i | input | 8 | Byte from program memory for this request |
| rsp_valid_o | output | 1 | Response present |
| rsp_allow_o | output | 1 | Read allowed |
| rsp_data_o | output | 8 | Returned byte (FFh when denied) |
| viol_o | output | 1 | Denied-read pulse |
| osc_full_gain_o | output | 1 | Oscillator gain select (1 = full) |

## Verification
Table reads are run from both code origins, with the inhibit bit in both states and at addresses 3FFFh and 4000h. This separates the origin rule from the address-boundary rule. Programmer reads are repeated with locking off, with scrambling on under a non-zero key, after lock, and after erase. Comparing them against fetches of the same byte shows whether scrambling is confined to programmer array reads. Security writes try to clear reserved bits, to set a cleared encryption bit again, and to collide with an erase. Each attempt is observed through a settings read or the gain pin.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

   typedef enum logic [1:0] {
      KIND_FETCH      = 2'b00,
      KIND_TABLE      = 2'b01,
      KIND_PROG_ARRAY = 2'b10,
      KIND_PROG_SREG  = 2'b11
   } req_kind_e;

   typedef struct packed {
      logic allow;     // read may proceed
      logic use_sreg;  // return the security byte instead of memory data
      logic scramble;  // pass the returned byte through the key mixer
   } verdict_t;

endpackage

// File: rtl/pmg_sec_reg.sv
module pmg_sec_reg #(
   parameter int DATA_W      = 8,
   parameter int LOCK_BIT    = 0,
   parameter int INHIBIT_BIT = 1,
   parameter int ENC_BIT     = 2,
   parameter int GAIN_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_i,
   input  logic              sec_we_i,
   input  logic [DATA_W-1:0] sec_wdata_i,
   input  logic              key_we_i,
   input  logic [DATA_W-1:0] key_wdata_i,
   output logic [DATA_W-1:0] sec_q,
   output logic [DATA_W-1:0] key_q
);

   localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
   localparam logic [DATA_W-1:0] LIVE_MASK = (ONE << LOCK_BIT) | (ONE << INHIBIT_BIT)
                                           | (ONE << ENC_BIT)  | (ONE << GAIN_BIT);
   localparam logic [DATA_W-1:0] RSVD_MASK = ~LIVE_MASK;

   logic [DATA_W-1:0] sec_d;
   logic [DATA_W-1:0] key_d;

   // Programming only pulls live bits low; reserved bits are pinned high.
   always_comb begin
      sec_d = sec_q;
      if (erase_i)
         sec_d = '1;
      else if (sec_we_i)
         sec_d = sec_q & (sec_wdata_i | RSVD_MASK);
   end

   always_comb begin
      key_d = key_q;
      if (erase_i)
         key_d = '0;
      else if (key_we_i)
         key_d = key_wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_q <= '1;
         key_q <= '0;
      end else begin
         sec_q <= sec_d;
         key_q <= key_d;
      end
   end

endmodule

// File: rtl/pmg_policy.sv
module pmg_policy
   import pmg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int INT_DEPTH   = 16384,
   parameter int LOCK_BIT    = 0,
   parameter int INHIBIT_BIT = 1,
   parameter int ENC_BIT     = 2
) (
   input  req_kind_e         kind_i,
   input  logic              ext_code_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] sec_i,
   output verdict_t          verdict_o
);

   localparam logic [ADDR_W:0] INT_LIMIT = (ADDR_W+1)'(INT_DEPTH);

   logic hits_internal;
   logic locked;
   logic inhibit_on;
   logic scramble_on;

   assign hits_internal = {1'b0, addr_i} < INT_LIMIT;
   assign locked        = ~sec_i[LOCK_BIT];
   assign inhibit_on    = ~sec_i[INHIBIT_BIT];
   assign scramble_on   = ~sec_i[ENC_BIT];

   always_comb begin
      verdict_o = '{allow: 1'b1, use_sreg: 1'b0, scramble: 1'b0};
      unique case (kind_i)
         KIND_FETCH: ;
         KIND_TABLE:
            verdict_o.allow = ~(ext_code_i & inhibit_on & hits_internal);
         KIND_PROG_ARRAY: begin
            verdict_o.allow    = ~locked;
            verdict_o.scramble = scramble_on;
         end
         KIND_PROG_SREG: begin
            verdict_o.allow    = ~locked;
            verdict_o.use_sreg = 1'b1;
         end
         default: verdict_o.allow = 1'b0;
      endcase
   end

endmodule

// File: rtl/pmg_scrambler.sv
module pmg_scrambler #(
   parameter int DATA_W        = 8,
   parameter int SCRAMBLE_KIND = 1   // 0: pass-through, 1: XOR with key
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] key_i,
   input  logic              en_i,
   output logic [DATA_W-1:0] data_o
);

   generate
      if (SCRAMBLE_KIND == 1) begin : g_xor
         assign data_o = en_i ? (data_i ^ key_i) : data_i;
      end else begin : g_plain
         logic unused_scr;
         assign unused_scr = ^{key_i, en_i};
         assign data_o     = data_i;
      end
   endgenerate

endmodule

// File: rtl/pmem_guard.sv
module pmem_guard
   import pmg_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int INT_DEPTH     = 16384,
   parameter int LOCK_BIT      = 0,
   parameter int INHIBIT_BIT   = 1,
   parameter int ENC_BIT       = 2,
   parameter int GAIN_BIT      = 7,
   parameter int SCRAMBLE_KIND = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase_i,
   input  logic              sec_we_i,
   input  logic [DATA_W-1:0] sec_wdata_i,
   input  logic              key_we_i,
   input  logic [DATA_W-1:0] key_wdata_i,
   input  logic              req_valid_i,
   input  logic [1:0]        req_kind_i,
   input  logic              req_ext_code_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              rsp_valid_o,
   output logic              rsp_allow_o,
   output logic [DATA_W-1:0] rsp_data_o,
   output logic              viol_o,
   output logic              osc_full_gain_o
);

   // Elaboration-time parameter checks
   generate
      if (INT_DEPTH < 1 || INT_DEPTH > (2 ** ADDR_W)) begin : g_bad_depth
         $error("pmem_guard: INT_DEPTH outside the address space");
      end
      if (LOCK_BIT >= DATA_W || INHIBIT_BIT >= DATA_W ||
          ENC_BIT >= DATA_W || GAIN_BIT >= DATA_W) begin : g_bad_pos
         $error("pmem_guard: security bit position beyond DATA_W");
      end
      if (LOCK_BIT == INHIBIT_BIT || LOCK_BIT == ENC_BIT || LOCK_BIT == GAIN_BIT ||
          INHIBIT_BIT == ENC_BIT || INHIBIT_BIT == GAIN_BIT || ENC_BIT == GAIN_BIT)
      begin : g_bad_overlap
         $error("pmem_guard: security bit positions overlap");
      end
      if (SCRAMBLE_KIND < 0 || SCRAMBLE_KIND > 1) begin : g_bad_kind
         $error("pmem_guard: unknown SCRAMBLE_KIND");
      end
   endgenerate

   logic [DATA_W-1:0] sec_q;
   logic [DATA_W-1:0] key_q;
   verdict_t          verdict;
   logic [DATA_W-1:0] src_byte;
   logic [DATA_W-1:0] mixed_byte;
   logic [DATA_W-1:0] out_byte;

   pmg_sec_reg #(
      .DATA_W      (DATA_W),
      .LOCK_BIT    (LOCK_BIT),
      .INHIBIT_BIT (INHIBIT_BIT),
      .ENC_BIT     (ENC_BIT),
      .GAIN_BIT    (GAIN_BIT)
   ) u_sec (
      .clk         (clk),
      .rst_n       (rst_n),
      .erase_i     (erase_i),
      .sec_we_i    (sec_we_i),
      .sec_wdata_i (sec_wdata_i),
      .key_we_i    (key_we_i),
      .key_wdata_i (key_wdata_i),
      .sec_q       (sec_q),
      .key_q       (key_q)
   );

   pmg_policy #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .INT_DEPTH   (INT_DEPTH),
      .LOCK_BIT    (LOCK_BIT),
      .INHIBIT_BIT (INHIBIT_BIT),
      .ENC_BIT     (ENC_BIT)
   ) u_policy (
      .kind_i      (req_kind_e'(req_kind_i)),
      .ext_code_i  (req_ext_code_i),
      .addr_i      (req_addr_i),
      .sec_i       (sec_q),
      .verdict_o   (verdict)
   );

   assign src_byte = verdict.use_sreg ? sec_q : mem_rdata_i;

   pmg_scrambler #(
      .DATA_W        (DATA_W),
      .SCRAMBLE_KIND (SCRAMBLE_KIND)
   ) u_scr (
      .data_i (src_byte),
      .key_i  (key_q),
      .en_i   (verdict.scramble),
      .data_o (mixed_byte)
   );

   assign out_byte = verdict.allow ? mixed_byte : '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_allow_o <= 1'b0;
         rsp_data_o  <= '1;
         viol_o      <= 1'b0;
      end else if (req_valid_i) begin
         rsp_valid_o <= 1'b1;
         rsp_allow_o <= verdict.allow;
         rsp_data_o  <= out_byte;
         viol_o      <= ~verdict.allow;
      end else begin
         rsp_valid_o <= 1'b0;
         rsp_allow_o <= 1'b0;
         rsp_data_o  <= '1;
         viol_o      <= 1'b0;
      end
   end

   assign osc_full_gain_o = sec_q[GAIN_BIT];

endmodule

// File: rtl/pmem_guard_chk.sv
module pmem_guard_chk #(
   parameter int DATA_W      = 8,
   parameter int LOCK_BIT    = 0,
   parameter int INHIBIT_BIT = 1,
   parameter int ENC_BIT     = 2,
   parameter int GAIN_BIT    = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              erase_i,
   input logic              req_valid_i,
   input logic [1:0]        req_kind_i,
   input logic [DATA_W-1:0] mem_rdata_i,
   input logic              rsp_valid_o,
   input logic              rsp_allow_o,
   input logic [DATA_W-1:0] rsp_data_o,
   input logic              viol_o,
   input logic [DATA_W-1:0] sec_q
);

   localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
   localparam logic [DATA_W-1:0] LIVE_MASK = (ONE << LOCK_BIT) | (ONE << INHIBIT_BIT)
                                           | (ONE << ENC_BIT)  | (ONE << GAIN_BIT);

   // R1
   erase_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_i |=> (sec_q == '1));

   // R2
   clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_i |=> ((sec_q & ~$past(sec_q)) == '0));

   // R2
   reserved_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> ((sec_q | LIVE_MASK) == '1));

   // R3
   fetch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_kind_i == 2'b00) |=>
         (rsp_allow_o && rsp_data_o == $past(mem_rdata_i)));

   // R6
   lock_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && req_kind_i[1] && !sec_q[LOCK_BIT]) |=> !rsp_allow_o);

   // R8
   deny_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && !rsp_allow_o) |-> (rsp_data_o == '1 && viol_o));

   // R8
   viol_only_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> (rsp_valid_o && !rsp_allow_o));

   // R9
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> rsp_valid_o);

   // R9
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> (!rsp_valid_o && !viol_o));

endmodule

bind pmem_guard pmem_guard_chk #(
   .DATA_W      (DATA_W),
   .LOCK_BIT    (LOCK_BIT),
   .INHIBIT_BIT (INHIBIT_BIT),
   .ENC_BIT     (ENC_BIT),
   .GAIN_BIT    (GAIN_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .erase_i     (erase_i),
   .req_valid_i (req_valid_i),
   .req_kind_i  (req_kind_i),
   .mem_rdata_i (mem_rdata_i),
   .rsp_valid_o (rsp_valid_o),
   .rsp_allow_o (rsp_allow_o),
   .rsp_data_o  (rsp_data_o),
   .viol_o      (viol_o),
   .sec_q       (sec_q)
);

// File: tb/pmem_guard_bench.sv
module pmem_guard_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        erase_i;
   logic        sec_we_i;
   logic [7:0]  sec_wdata_i;
   logic        key_we_i;
   logic [7:0]  key_wdata_i;
   logic        req_valid_i;
   logic [1:0]  req_kind_i;
   logic        req_ext_code_i;
   logic [15:0] req_addr_i;
   logic [7:0]  mem_rdata_i;
   logic        rsp_valid_o;
   logic        rsp_allow_o;
   logic [7:0]  rsp_data_o;
   logic        viol_o;
   logic        osc_full_gain_o;

   int checks = 0;
   int errors = 0;

   logic [8:0] exp_q[$];   // {allow, data}
   string      tag_q[$];

   always #4 clk = ~clk;   // 125 MHz

   pmem_guard u_pmem_guard (
      .clk             (clk),
      .rst_n           (rst_n),
      .erase_i         (erase_i),
      .sec_we_i        (sec_we_i),
      .sec_wdata_i     (sec_wdata_i),
      .key_we_i        (key_we_i),
      .key_wdata_i     (key_wdata_i),
      .req_valid_i     (req_valid_i),
      .req_kind_i      (req_kind_i),
      .req_ext_code_i  (req_ext_code_i),
      .req_addr_i      (req_addr_i),
      .mem_rdata_i     (mem_rdata_i),
      .rsp_valid_o     (rsp_valid_o),
      .rsp_allow_o     (rsp_allow_o),
      .rsp_data_o      (rsp_data_o),
      .viol_o          (viol_o),
      .osc_full_gain_o (osc_full_gain_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic defaults();
      erase_i        = 1'b0;
      sec_we_i       = 1'b0;
      sec_wdata_i    = 8'h00;
      key_we_i       = 1'b0;
      key_wdata_i    = 8'h00;
      req_valid_i    = 1'b0;
      req_kind_i     = 2'b00;
      req_ext_code_i = 1'b0;
      req_addr_i     = 16'h0000;
      mem_rdata_i    = 8'h00;
   endtask

   // Driver: issue one request and queue what the response must be.
   task automatic rd(input logic [1:0] kind, input logic ext, input logic [15:0] addr,
                     input logic [7:0] mdata, input logic allow, input logic [7:0] data,
                     input string tag);
      @(negedge clk);
      defaults();
      req_valid_i    = 1'b1;
      req_kind_i     = kind;
      req_ext_code_i = ext;
      req_addr_i     = addr;
      mem_rdata_i    = mdata;
      exp_q.push_back({allow, data});
      tag_q.push_back(tag);
   endtask

   task automatic wsec(input logic [7:0] v);
      @(negedge clk);
      defaults();
      sec_we_i    = 1'b1;
      sec_wdata_i = v;
      @(negedge clk);
      defaults();
   endtask

   task automatic wkey(input logic [7:0] v);
      @(negedge clk);
      defaults();
      key_we_i    = 1'b1;
      key_wdata_i = v;
      @(negedge clk);
      defaults();
   endtask

   task automatic do_erase(input logic with_write);
      @(negedge clk);
      defaults();
      erase_i     = 1'b1;
      sec_we_i    = with_write;
      sec_wdata_i = 8'h00;
      @(negedge clk);
      defaults();
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      defaults();
      repeat (n) @(negedge clk);
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      logic [8:0] e;
      string      t;
      if (rst_n === 1'b1 && rsp_valid_o === 1'b1) begin
         if (exp_q.size() == 0) begin
            chk("R9 response with no request", 1, 0);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({t, " allow"}, 32'(rsp_allow_o), 32'(e[8]));
            chk({t, " data"},  32'(rsp_data_o),  32'(e[7:0]));
            chk({t, " viol R8"}, 32'(viol_o),    32'(!e[8]));
         end
      end
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      defaults();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 gain after reset",  32'(osc_full_gain_o), 1);
      chk("R9 valid after reset", 32'(rsp_valid_o), 0);
      chk("R8 viol after reset",  32'(viol_o), 0);

      rd(2'b11, 1'b0, 16'h0000, 8'h00, 1'b1, 8'hFF, "R1 R12 settings after reset");
      rd(2'b10, 1'b0, 16'h0010, 8'h5A, 1'b1, 8'h5A, "R1 array read key zero");
      rd(2'b00, 1'b0, 16'h0100, 8'h5A, 1'b1, 8'h5A, "R3 internal fetch");
      rd(2'b00, 1'b1, 16'h8000, 8'h33, 1'b1, 8'h33, "R3 external fetch");
      rd(2'b01, 1'b1, 16'h0010, 8'h77, 1'b1, 8'h77, "R5 table ext code inhibit off");

      wsec(8'hFD);   // clear inhibit bit 1
      rd(2'b11, 1'b0, 16'h0000, 8'h00, 1'b1, 8'hFD, "R2 settings after clear bit1");
      rd(2'b01, 1'b1, 16'h3FFF, 8'h44, 1'b0, 8'hFF, "R4 table ext 3FFF denied");
      rd(2'b01, 1'b1, 16'h0000, 8'h45, 1'b0, 8'hFF, "R8 back-to-back deny");
      rd(2'b01, 1'b1, 16'h4000, 8'h11, 1'b1, 8'h11, "R4 table ext 4000 allowed");
      rd(2'b01, 1'b0, 16'h0020, 8'h22, 1'b1, 8'h22, "R5 table internal code");

      wkey(8'h3C);
      wsec(8'h83);   // clear enc bit 2, try to clear reserved bits
      rd(2'b11, 1'b0, 16'h0000, 8'h00, 1'b1, 8'hF9, "R2 R7 reserved held, settings unscrambled");
      rd(2'b10, 1'b0, 16'h0005, 8'hA5, 1'b1, 8'h99, "R7 array read scrambled");
      rd(2'b00, 1'b0, 16'h0005, 8'hA5, 1'b1, 8'hA5, "R7 fetch not scrambled");
      rd(2'b01, 1'b0, 16'h0005, 8'hA5, 1'b1, 8'hA5, "R7 table not scrambled");

      wsec(8'hFF);   // attempt to set bits back
      rd(2'b11, 1'b0, 16'h0000, 8'h00, 1'b1, 8'hF9, "R11 enc bit stays cleared");

      wsec(8'h7F);   // clear gain bit 7
      chk("R10 gain cleared", 32'(osc_full_gain_o), 0);

      wsec(8'hFE);   // lock
      rd(2'b10, 1'b0, 16'h0005, 8'hA5, 1'b0, 8'hFF, "R6 array read locked");
      rd(2'b11, 1'b0, 16'h0000, 8'h00, 1'b0, 8'hFF, "R6 settings read locked");
      rd(2'b00, 1'b0, 16'h0005, 8'hA5, 1'b1, 8'hA5, "R3 fetch while locked");

      do_erase(1'b0);
      chk("R1 gain after erase", 32'(osc_full_gain_o), 1);
      rd(2'b11, 1'b0, 16'h0000, 8'h00, 1'b1, 8'hFF, "R1 settings after erase");
      rd(2'b10, 1'b0, 16'h0005, 8'h5A, 1'b1, 8'h5A, "R1 array read after erase");
      rd(2'b01, 1'b1, 16'h0001, 8'h66, 1'b1, 8'h66, "R5 table ext after erase");

      wsec(8'h00);   // clears all live bits incl. lock
      do_erase(1'b1); // erase collides with a write of 00h
      rd(2'b11, 1'b0, 16'h0000, 8'h00, 1'b1, 8'hFF, "R2 erase beats write");

      idle(3);
      chk("R9 no response when idle", 32'(rsp_valid_o), 0);
      chk("R9 no viol when idle",     32'(viol_o), 0);
      chk("R9 all responses seen",    32'(exp_q.size()), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule